// File: doc/BRIEF.md
# Registered Complex Butterfly Datapath

This block computes one radix-2 decimation-in-time butterfly on packed complex words. A single strobe captures the upper operand A, the lower operand B and the rotation factor W into a register stage. Combinational logic then forms the rotated product P = W×B and presents both butterfly results, A+P and A−P, so that they can be written back into the transform memory on the next cycle.

Each complex word is 32 bits wide. Bits [31:16] hold the real part and bits [15:0] the imaginary part. Both parts are signed Q1.15 values. Each of the four partial products of the complex multiply is rounded back to 16 bits by an arithmetic right shift of 15. All sums and differences wrap in two's complement, and there is no saturation. A valid flag marks the one cycle in which a freshly loaded result is shown. Between loads the results stay unchanged.

Top module: `bfly_core`

## Requirements
- R1: A complex word carries its real part in bits [31:16] and its imaginary part in bits [15:0]. Both parts are signed Q1.15. With W = 0, both outputs equal A exactly, part for part.
- R2: The product P = W×B uses (wr+j·wi)(br+j·bi) = (wr·br − wi·bi) + j(wr·bi + wi·br). Each 32-bit partial product is arithmetically shifted right by 15 and truncated to 16 bits. The difference and the sum are then taken modulo 2^16.
- R3: sum_o equals A + P, computed separately on the real part and the imaginary part, modulo 2^16.
- R4: dif_o equals A − P, computed separately on the real part and the imaginary part, modulo 2^16.
- R5: A, B and W are captured only on a clock edge that samples ld_i high. While ld_i stays low, sum_o and dif_o hold their values whatever appears on a_i, b_i and w_i.
- R6: vld_o is high in the cycle right after an edge that samples ld_i high, and low after an edge that samples ld_i low.
- R7: A synchronous active-high reset clears the operand registers and vld_o. After an edge that samples rst high, vld_o is 0 and sum_o and dif_o are 0. Reset takes priority over ld_i.
- R8: Overflow wraps and is never saturated. With A = B = 0x7FFF7FFF and W = 0x7FFF0000, the real part of sum_o is 0x7FFF + 0x7FFE, which wraps to 0xFFFD. A partial product of −1·−1 (0x8000·0x8000) gives +32768 after the shift, which wraps to 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_i | input | 1 | Load strobe for the three operands |
| a_i | input | 32 | Operand A, packed {real, imag} |
| b_i | input | 32 | Operand B, packed {real, imag} |
| w_i | input | 32 | Rotation factor W, packed {real, imag} |
| sum_o | output | 32 | Result A + W×B |
| dif_o | output | 32 | Result A − W×B |
| vld_o | output | 1 | High in the cycle after a load |

## Verification
The assertions assume that ld_i and the operand buses are stable around each rising edge. They also assume that a property attempt begins only after reset has been sampled at least once, so that the register stage never holds unknown values while a check is active. The stimulus meets these assumptions by driving every input on the falling edge only and by holding reset through the first cycles. Between loads it changes the operand buses freely while ld_i is low, so that the hold property is tested against changing data and not against idle inputs.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned HALF_W_DEF = 16;
  localparam int unsigned FRAC_DEF   = 15;
  localparam int unsigned NUM_OPND   = 3;
  localparam int unsigned OPND_A     = 0;
  localparam int unsigned OPND_B     = 1;
  localparam int unsigned OPND_W     = 2;
endpackage

// File: rtl/bfly_opnd_reg.sv
module bfly_opnd_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter int unsigned HW   = 16,
  parameter int unsigned FRAC = 15
) (
  input  logic [2*HW-1:0] x,
  input  logic [2*HW-1:0] y,
  output logic [2*HW-1:0] p
);
  localparam int unsigned PW = 2 * HW;

  logic signed [HW-1:0] xr, xi, yr, yi;
  logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [HW-1:0] s_rr, s_ii, s_ri, s_ir;
  logic signed [HW-1:0] p_re, p_im;

  always_comb begin
    xr   = x[PW-1:HW];
    xi   = x[HW-1:0];
    yr   = y[PW-1:HW];
    yi   = y[HW-1:0];
    m_rr = PW'(xr) * PW'(yr);
    m_ii = PW'(xi) * PW'(yi);
    m_ri = PW'(xr) * PW'(yi);
    m_ir = PW'(xi) * PW'(yr);
    s_rr = HW'(m_rr >>> FRAC);
    s_ii = HW'(m_ii >>> FRAC);
    s_ri = HW'(m_ri >>> FRAC);
    s_ir = HW'(m_ir >>> FRAC);
    p_re = s_rr - s_ii;
    p_im = s_ri + s_ir;
    p    = {p_re, p_im};
  end
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int unsigned HW = 16
) (
  input  logic [2*HW-1:0] a,
  input  logic [2*HW-1:0] p,
  output logic [2*HW-1:0] sum,
  output logic [2*HW-1:0] dif
);
  for (genvar g = 0; g < 2; g++) begin : g_part
    logic [HW-1:0] a_h, p_h;
    assign a_h = a[g*HW +: HW];
    assign p_h = p[g*HW +: HW];
    assign sum[g*HW +: HW] = a_h + p_h;
    assign dif[g*HW +: HW] = a_h - p_h;
  end
endmodule

// File: rtl/bfly_core.sv
module bfly_core #(
  parameter int unsigned HW   = bfly_pkg::HALF_W_DEF,
  parameter int unsigned FRAC = bfly_pkg::FRAC_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_i,
  input  logic [2*HW-1:0] a_i,
  input  logic [2*HW-1:0] b_i,
  input  logic [2*HW-1:0] w_i,
  output logic [2*HW-1:0] sum_o,
  output logic [2*HW-1:0] dif_o,
  output logic            vld_o
);
  localparam int unsigned WW = 2 * HW;

  logic [WW-1:0] opnd_d [bfly_pkg::NUM_OPND];
  logic [WW-1:0] opnd_q [bfly_pkg::NUM_OPND];
  logic [WW-1:0] prod;
  logic          vld_q;

  assign opnd_d[bfly_pkg::OPND_A] = a_i;
  assign opnd_d[bfly_pkg::OPND_B] = b_i;
  assign opnd_d[bfly_pkg::OPND_W] = w_i;

  for (genvar k = 0; k < bfly_pkg::NUM_OPND; k++) begin : g_opnd
    bfly_opnd_reg #(.WIDTH(WW)) reg_i (
      .clk (clk),
      .rst (rst),
      .en  (ld_i),
      .d   (opnd_d[k]),
      .q   (opnd_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= ld_i;
    end
  end

  bfly_cmul #(.HW(HW), .FRAC(FRAC)) cmul_i (
    .x (opnd_q[bfly_pkg::OPND_W]),
    .y (opnd_q[bfly_pkg::OPND_B]),
    .p (prod)
  );

  bfly_addsub #(.HW(HW)) addsub_i (
    .a   (opnd_q[bfly_pkg::OPND_A]),
    .p   (prod),
    .sum (sum_o),
    .dif (dif_o)
  );

  assign vld_o = vld_q;
endmodule

// File: rtl/bfly_core_chk.sv
module bfly_core_chk #(
  parameter int unsigned HW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            ld_i,
  input logic [2*HW-1:0] a_i,
  input logic [2*HW-1:0] sum_o,
  input logic [2*HW-1:0] dif_o,
  input logic            vld_o
);
  logic [HW-1:0] pair_re, pair_im;
  assign pair_re = sum_o[2*HW-1:HW] + dif_o[2*HW-1:HW];
  assign pair_im = sum_o[HW-1:0] + dif_o[HW-1:0];

  AST_VLD_AFTER_LD: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> vld_o); // R6
  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> !vld_o); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> ($stable(sum_o) && $stable(dif_o))); // R5
  AST_PAIR_RE: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (pair_re == {$past(a_i[2*HW-2:HW]), 1'b0})); // R3
  AST_PAIR_IM: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (pair_im == {$past(a_i[HW-2:0]), 1'b0})); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!vld_o && sum_o == '0 && dif_o == '0)); // R7
endmodule

bind bfly_core bfly_core_chk #(.HW(HW)) chk_i (.*);

// File: tb/bfly_core_tb_top.sv
`timescale 1ns/1ps
module bfly_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, w_i = '0;
  logic [31:0] sum_o, dif_o;
  logic        vld_o;

  int    n_vec = 0, n_bad = 0, n_cyc = 0;
  string phase = "R7";
  bit    started = 0;
  bit    done = 0;

  int m_ar = 0, m_ai = 0, m_br = 0, m_bi = 0, m_wr = 0, m_wi = 0;
  bit m_vld = 0;

  always #4 clk = ~clk;

  bfly_core dut_i (
    .clk(clk), .rst(rst), .ld_i(ld_i), .a_i(a_i), .b_i(b_i), .w_i(w_i),
    .sum_o(sum_o), .dif_o(dif_o), .vld_o(vld_o)
  );

  function automatic int s16(input int v);
    int t;
    t = v & 32'h0000_ffff;
    return (t >= 32768) ? t - 65536 : t;
  endfunction

  function automatic int hi(input logic [31:0] x);
    return s16(int'(x[31:16]));
  endfunction

  function automatic int lo(input logic [31:0] x);
    return s16(int'(x[15:0]));
  endfunction

  function automatic int qmul(input int x, input int y);
    int p;
    p = x * y;
    return s16(p >>> 15);
  endfunction

  // behavioural model of the operand stage
  always @(posedge clk) begin
    started <= 1;
    n_cyc   <= n_cyc + 1;
    if (rst) begin
      m_ar <= 0; m_ai <= 0; m_br <= 0; m_bi <= 0; m_wr <= 0; m_wi <= 0;
      m_vld <= 0;
    end else begin
      m_vld <= ld_i;
      if (ld_i) begin
        m_ar <= hi(a_i); m_ai <= lo(a_i);
        m_br <= hi(b_i); m_bi <= lo(b_i);
        m_wr <= hi(w_i); m_wi <= lo(w_i);
      end
    end
  end

  task automatic cmp(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) at cycle %0d: actual %h expected %h",
               req, phase, n_cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      int pr, pi;
      pr = s16(qmul(m_wr, m_br) - qmul(m_wi, m_bi));
      pi = s16(qmul(m_wr, m_bi) + qmul(m_wi, m_br));
      cmp("R6 vld", int'(vld_o), int'(m_vld));
      cmp("R3 sum.re", hi(sum_o), s16(m_ar + pr));
      cmp("R3 sum.im", lo(sum_o), s16(m_ai + pi));
      cmp("R4 dif.re", hi(dif_o), s16(m_ar - pr));
      cmp("R4 dif.im", lo(dif_o), s16(m_ai - pi));
    end
  end

  task automatic load(input logic [31:0] a, input logic [31:0] b, input logic [31:0] w);
    @(negedge clk);
    ld_i = 1'b1; a_i = a; b_i = b; w_i = w;
    @(negedge clk);
    ld_i = 1'b0;
  endtask

  task automatic idle_noise(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_i = 1'b0; a_i = $urandom; b_i = $urandom; w_i = $urandom;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    phase = "R7";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1";
    load(32'h0001_0002, 32'h1234_5678, 32'h0000_0000);
    load(32'hFFFF_8000, 32'h7FFF_8001, 32'h0000_0000);
    phase = "R2";
    load(32'h1000_F000, 32'h4000_2000, 32'h7FFF_0000);
    load(32'h0000_0000, 32'h4000_2000, 32'h0000_7FFF);
    load(32'h0100_0200, 32'h3000_D000, 32'h5A82_A57E);
    load(32'h0000_0000, 32'h8000_8000, 32'h8000_8000);
    phase = "R8";
    load(32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_0000);
    load(32'h8000_8000, 32'h7FFF_7FFF, 32'h7FFF_7FFF);
    load(32'h0000_0000, 32'h8000_0000, 32'h8000_0000);
    phase = "R5";
    idle_noise(8);
    load(32'h2222_3333, 32'h1111_4444, 32'h6000_2000);
    idle_noise(6);
    phase = "R6";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ld_i = 1'b1; a_i = $urandom; b_i = $urandom; w_i = $urandom;
    end
    @(negedge clk);
    ld_i = 1'b0;
    phase = "R3";
    for (int i = 0; i < 300; i++) begin
      load($urandom, $urandom, $urandom);
      idle_noise($urandom_range(0, 3));
    end
    phase = "R7";
    @(negedge clk);
    ld_i = 1'b1; rst = 1'b1; a_i = 32'h1234_5678; b_i = 32'h7FFF_7FFF; w_i = 32'h7FFF_0000;
    @(negedge clk);
    ld_i = 1'b0; rst = 1'b0;
    idle_noise(3);
    phase = "R4";
    for (int i = 0; i < 100; i++) load($urandom, $urandom, $urandom);
    idle_noise(2);
    finish_run();
  end

  always @(posedge clk) begin
    if (n_cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", n_cyc);
      finish_run();
    end
  end
endmodule